// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose pin controller built from a parameterized number of 8-pin ports. The legal port counts are 3, 5 and 7, which give 24, 40 or 56 pins. For each pin, software can write an output value, pick one of four drive modes and switch the pull-up off. The block detects a chosen edge on the pin's input, latches it as a sticky event, and ORs the enabled events of each port onto that port's interrupt line. Software can also raise an event by writing a force register.

Pin inputs reach the edge detector either directly or through a two-flop synchronizer. One bit in the global control register makes that choice. The same register holds a block clock request bit, and it reports a core version ID and the number of 8-pin cores. The register bus is a simple synchronous interface. Writes take effect at the clock edge that samples them, and read data is combinational from the address.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every port register and both writable control bits are 0. As a result, pin_oe is all zero, irq is all zero, pull_en is all one and pin_out is all zero.
- R2: Port p has a 0x30-byte window starting at byte address p*0x30. Register offsets inside the window:
  - 0x04: input level, read-only.
  - 0x08: output value.
  - 0x0C: drive mode.
  - 0x10: pull-up disable.
  - 0x14: event.
  - 0x18: interrupt enable.
  - 0x1C: force.
  - 0x20: edge select.
  Byte address 0x00 is the global control register. Any other offset reads 0, and writes to it are ignored.
- R3: The drive mode register gives each pin a 2-bit field; pin n uses bits [2n+1:2n]. Code 0 is input and never drives. Code 1 is push-pull and always drives. Code 2 drives only while the output value is 0. Code 3 drives only while the output value is 1. The drive decision appears on pin_oe.
- R4: pin_out carries the output value register bit for every pin, whatever the mode.
- R5: A 1 in the pull-up disable register clears that pin's pull_en output. A 0 keeps pull_en at 1. Only the low 8 bits of the register exist.
- R6: Edge select bit n = 1 latches a rising edge of pin n as an event, and 0 latches a falling edge. The opposite edge leaves the event bit unchanged. An event bit stays set until software clears it.
- R7: Writing 1 to an event bit clears it, and writing 0 leaves it alone. An edge or force arriving in the same cycle wins over the clear.
- R8: Writing 1 to a force bit sets the matching event bit at that write's clock edge. The force register always reads 0.
- R9: irq[p] is high exactly when some pin of port p has both its event bit and its enable bit set.
- R10: With the synchronizer select bit at 0, a pin change is latched as an event at the first clock edge after it. With the bit at 1, the new level reaches the input register after two edges and the event after three. The input register returns the level used for edge detection in every drive mode.
- R11: The control register layout:
  - Bit 0 is a read/write clock request.
  - Bit 1 is the read/write synchronizer select.
  - Bits [8:2] hold the version ID parameter and are read-only.
  - Bits [15:9] hold the port count and are read-only.
  - Bits [31:16] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Drive enable per pin |
| pull_en | output | NPINS | Pull-up enable per pin |
| irq | output | NUM_PORTS | One interrupt per port |

## Verification
A wrong mode or output-value bit shows up on pin_oe and pin_out in the cycle after the write. A lost or spurious event bit shows up on irq once its enable is set, and it is also visible in the event register read back at once. A synchronizer fault moves the event by one or two clock edges. The bench therefore samples both the input register and the event register at each edge after a pin change, so an early or late capture is caught in the cycle where it happens.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int PORT_SPAN     = 'h30;

  localparam logic [5:0] OFS_CTRL  = 6'h00;
  localparam logic [5:0] OFS_LEVEL = 6'h04;
  localparam logic [5:0] OFS_VALUE = 6'h08;
  localparam logic [5:0] OFS_MODE  = 6'h0C;
  localparam logic [5:0] OFS_NOPU  = 6'h10;
  localparam logic [5:0] OFS_EVT   = 6'h14;
  localparam logic [5:0] OFS_IEN   = 6'h18;
  localparam logic [5:0] OFS_FORCE = 6'h1C;
  localparam logic [5:0] OFS_EDGE  = 6'h20;

  typedef enum logic [1:0] {
    DM_INPUT       = 2'd0,
    DM_PUSH_PULL   = 2'd1,
    DM_SINK_ONLY   = 2'd2,
    DM_SOURCE_ONLY = 2'd3
  } drive_mode_e;

  // Whether a pin drives its pad, given its mode and output value.
  function automatic logic pin_drives(input logic [1:0] mode, input logic val);
    case (drive_mode_e'(mode))
      DM_PUSH_PULL:   return 1'b1;
      DM_SINK_ONLY:   return ~val;
      DM_SOURCE_ONLY: return val;
      default:        return 1'b0;
    endcase
  endfunction

  // Per-pin edge hit: rise_sel 1 picks the rising edge, 0 the falling edge.
  function automatic logic [PINS_PER_PORT-1:0] edge_hits(
      input logic [PINS_PER_PORT-1:0] rise_sel,
      input logic [PINS_PER_PORT-1:0] cur,
      input logic [PINS_PER_PORT-1:0] prev);
    return (rise_sel & cur & ~prev) | (~rise_sel & ~cur & prev);
  endfunction

  // Global control word: clock request, sync select, version, core count.
  function automatic logic [31:0] ctrl_word(input logic clk_req, input logic sync_sel,
                                            input logic [6:0] ver, input logic [6:0] cores);
    return {16'h0, cores, ver, sync_sel, clk_req};
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] level
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw;
      stage2_q <= stage1_q;
    end
  end

  assign level = sync_en ? stage2_q : raw;

  // With the synchronizer held on, the level lags the pins by two edges.
  p_sync_two_edges_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && $past(sync_en) && $past(sync_en, 2)) |-> (level == $past(raw, 2)));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [15:0]              wdata,
  input  logic [PINS_PER_PORT-1:0] level,
  output logic [31:0]              rdata,
  output logic [PINS_PER_PORT-1:0] pin_out,
  output logic [PINS_PER_PORT-1:0] pin_oe,
  output logic [PINS_PER_PORT-1:0] pull_en,
  output logic                     irq
);
  localparam int NP = PINS_PER_PORT;

  logic          hit;
  logic [5:0]    ofs;
  logic [NP-1:0] value_q, nopu_q, evt_q, ien_q, rise_q, prev_q;
  logic [2*NP-1:0] mode_q;
  logic [NP-1:0] evt_set_w, evt_clr_w;
  logic          wr_value, wr_mode, wr_nopu, wr_evt, wr_ien, wr_force, wr_edge;

  assign hit = (int'(addr) >= BASE) && (int'(addr) < BASE + PORT_SPAN);
  assign ofs = 6'(int'(addr) - BASE);

  assign wr_value = wr_stb && hit && (ofs == OFS_VALUE);
  assign wr_mode  = wr_stb && hit && (ofs == OFS_MODE);
  assign wr_nopu  = wr_stb && hit && (ofs == OFS_NOPU);
  assign wr_evt   = wr_stb && hit && (ofs == OFS_EVT);
  assign wr_ien   = wr_stb && hit && (ofs == OFS_IEN);
  assign wr_force = wr_stb && hit && (ofs == OFS_FORCE);
  assign wr_edge  = wr_stb && hit && (ofs == OFS_EDGE);

  // Named event wires: what sets and what clears each sticky bit.
  assign evt_set_w = edge_hits(rise_q, level, prev_q) | (wr_force ? wdata[NP-1:0] : '0);
  assign evt_clr_w = wr_evt ? wdata[NP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      mode_q  <= '0;
      nopu_q  <= '0;
      evt_q   <= '0;
      ien_q   <= '0;
      rise_q  <= '0;
      prev_q  <= '0;
    end else begin
      if (wr_value) value_q <= wdata[NP-1:0];
      if (wr_mode)  mode_q  <= wdata[2*NP-1:0];
      if (wr_nopu)  nopu_q  <= wdata[NP-1:0];
      if (wr_ien)   ien_q   <= wdata[NP-1:0];
      if (wr_edge)  rise_q  <= wdata[NP-1:0];
      evt_q  <= (evt_q & ~evt_clr_w) | evt_set_w;
      prev_q <= level;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (ofs)
        OFS_LEVEL: rdata[NP-1:0]   = level;
        OFS_VALUE: rdata[NP-1:0]   = value_q;
        OFS_MODE:  rdata[2*NP-1:0] = mode_q;
        OFS_NOPU:  rdata[NP-1:0]   = nopu_q;
        OFS_EVT:   rdata[NP-1:0]   = evt_q;
        OFS_IEN:   rdata[NP-1:0]   = ien_q;
        OFS_EDGE:  rdata[NP-1:0]   = rise_q;
        default:   rdata           = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    assign pin_oe[i] = pin_drives(mode_q[2*i +: 2], value_q[i]);

    p_input_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b00) |-> !pin_oe[i]);
  end

  assign pin_out = value_q;
  assign pull_en = ~nopu_q;
  assign irq     = |(evt_q & ien_q);

  p_set_latches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set_w != '0) |=> ((evt_q & $past(evt_set_w)) == $past(evt_set_w)));

  p_no_spurious_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q) & ~$past(evt_set_w)) == '0));

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr_w != '0) |=> ((evt_q & $past(evt_clr_w & ~evt_set_w)) == '0));

  p_force_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_force |=> ((evt_q & $past(wdata[NP-1:0])) == $past(wdata[NP-1:0])));

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int  NUM_PORTS  = 3,
  parameter int  VERSION_ID = 21,
  localparam int NPINS      = NUM_PORTS * PINS_PER_PORT,
  localparam int ADDR_W     = $clog2(NUM_PORTS * PORT_SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic [NUM_PORTS-1:0] irq
);
  logic             wr_stb, ctrl_hit;
  logic             clk_req_q, sync_sel_q;
  logic [NPINS-1:0] level;
  logic [31:0]      port_rd [NUM_PORTS];
  logic [31:0]      rd_or;
  logic             wdata_unused;

  assign wr_stb       = bus_en && bus_we;
  assign ctrl_hit     = (bus_addr == '0);
  assign wdata_unused = ^bus_wdata[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_req_q  <= 1'b0;
      sync_sel_q <= 1'b0;
    end else if (wr_stb && ctrl_hit) begin
      clk_req_q  <= bus_wdata[0];
      sync_sel_q <= bus_wdata[1];
    end
  end

  gpio_in_sync #(.WIDTH(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_en (sync_sel_q),
    .raw     (pin_in),
    .level   (level)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_edge_port #(.ADDR_W(ADDR_W), .BASE(p * PORT_SPAN)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .addr    (bus_addr),
      .wdata   (bus_wdata[15:0]),
      .level   (level[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .rdata   (port_rd[p]),
      .pin_out (pin_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pin_oe  (pin_oe[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pull_en (pull_en[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .irq     (irq[p])
    );
  end

  always_comb begin
    rd_or = '0;
    for (int p = 0; p < NUM_PORTS; p++) rd_or |= port_rd[p];
  end

  assign bus_rdata = rd_or |
    (ctrl_hit ? ctrl_word(clk_req_q, sync_sel_q, 7'(VERSION_ID), 7'(NUM_PORTS)) : 32'h0);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((irq == '0) && (pin_oe == '0)));

  p_ctrl_id_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |-> ((bus_rdata[31:16] == 16'h0) && (bus_rdata[15:9] == 7'(NUM_PORTS)) &&
                  (bus_rdata[8:2] == 7'(VERSION_ID))));
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  localparam int NUM_PORTS = 3;
  localparam int NPINS     = NUM_PORTS * 8;
  localparam int ADDR_W    = $clog2(NUM_PORTS * 48);
  localparam logic [31:0] CTRL_ID = (32'(NUM_PORTS) << 9) | (32'd21 << 2);

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 9'h000, CTRL_ID,        8'd11}, // R11 identity after reset
    '{1'b1, 9'h000, 32'hFFFF_FFFF,  8'd11},
    '{1'b0, 9'h000, CTRL_ID | 3,    8'd11}, // R11 only bits 1:0 writable
    '{1'b1, 9'h000, 32'h0,          8'd11},
    '{1'b0, 9'h000, CTRL_ID,        8'd11},
    '{1'b1, 9'h008, 32'h0000_00A5,  8'd4},
    '{1'b0, 9'h008, 32'h0000_00A5,  8'd2},  // R2 port 0 value
    '{1'b1, 9'h038, 32'h0000_003C,  8'd2},
    '{1'b0, 9'h038, 32'h0000_003C,  8'd2},  // R2 port 1 value
    '{1'b1, 9'h06C, 32'h0000_E4E4,  8'd3},
    '{1'b0, 9'h06C, 32'h0000_E4E4,  8'd3},  // R3 port 2 modes
    '{1'b0, 9'h030, 32'h0,          8'd2},  // R2 port 1 offset 0 unmapped
    '{1'b0, 9'h024, 32'h0,          8'd2},  // R2 past last register
    '{1'b1, 9'h010, 32'hFFFF_FFFF,  8'd5},
    '{1'b0, 9'h010, 32'h0000_00FF,  8'd5},  // R5 8 bits only
    '{1'b1, 9'h04C, 32'h0,          8'd8},
    '{1'b0, 9'h04C, 32'h0,          8'd8},  // R8 force reads 0
    '{1'b0, 9'h004, 32'h0,          8'd10}, // R10 pins low
    '{1'b1, 9'h050, 32'hFFFF_FF5A,  8'd6},
    '{1'b0, 9'h050, 32'h0000_005A,  8'd6},  // R6 edge select readback
    '{1'b0, 9'h044, 32'h0,          8'd6}   // R6 no events yet
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_en, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NPINS-1:0]  pin_in, pin_out, pin_oe, pull_en;
  logic [NUM_PORTS-1:0] irq;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl #(.NUM_PORTS(NUM_PORTS), .VERSION_ID(21)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[ADDR_W-1:0];
    #2 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 pull_en", 32'(pull_en), 32'(24'hFF_FFFF));
    check("R1 pin_out", 32'(pin_out), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].data);
      end
    end

    // R5 pull-up outputs, R4 output values
    check("R5 pull_en after disable", 32'(pull_en), 32'(24'hFFFF_00));
    check("R4 pin_out port0/1", 32'(pin_out[15:0]), 32'h3CA5);
    // R3 modes 0,1,2,3 per nibble with value 0, then value 1
    check("R3 oe value0", 32'(pin_oe), 32'(24'h66_0000));
    bus_write(9'h068, 32'hFF);
    check("R3 oe value1", 32'(pin_oe), 32'(24'hAA_0000));
    check("R4 pin_out port2", 32'(pin_out[23:16]), 32'hFF);

    // R6 edges, sync bypassed: pin0 rising, others falling
    bus_write(9'h020, 32'h01);
    bus_write(9'h018, 32'h01);
    pin_in[0] = 1'b1;
    step();
    bus_read(9'h014, rd);
    check("R10 bypass event after one edge", rd, 32'h01);
    check("R9 irq on enabled event", 32'(irq), 32'h1);
    pin_in[1] = 1'b1;
    step();
    bus_read(9'h014, rd);
    check("R6 rise ignored on falling pin", rd, 32'h01);
    pin_in[1] = 1'b0;
    step();
    bus_read(9'h014, rd);
    check("R6 falling edge latched", rd, 32'h03);
    bus_write(9'h014, 32'h01);
    bus_read(9'h014, rd);
    check("R7 write-one clears", rd, 32'h02);
    check("R9 irq off with disabled event", 32'(irq), 32'h0);
    bus_write(9'h018, 32'h03);
    check("R9 irq on after enable", 32'(irq), 32'h1);
    bus_write(9'h014, 32'h02);
    check("R7 irq drops after clear", 32'(irq), 32'h0);

    // R8 force on port 1
    bus_write(9'h04C, 32'h80);
    bus_read(9'h044, rd);
    check("R8 force sets event", rd, 32'h80);
    bus_read(9'h04C, rd);
    check("R8 force reads zero", rd, 32'h0);
    check("R9 forced event not enabled", 32'(irq), 32'h0);
    bus_write(9'h048, 32'h80);
    check("R9 port1 irq", 32'(irq), 32'h2);
    bus_write(9'h044, 32'h80);
    check("R7 port1 cleared", 32'(irq), 32'h0);

    // R10 synchronizer on: level after two edges, event after three
    bus_write(9'h000, 32'h2);
    bus_read(9'h000, rd);
    check("R11 sync bit readback", rd, CTRL_ID | 2);
    pin_in[0] = 1'b0;
    repeat (4) step();
    bus_read(9'h014, rd);
    check("R6 falling on rising pin ignored", rd, 32'h0);
    pin_in[0] = 1'b1;
    step();
    bus_read(9'h004, rd);
    check("R10 level after one edge", rd, 32'h0);
    step();
    bus_read(9'h004, rd);
    check("R10 level after two edges", rd, 32'h01);
    bus_read(9'h014, rd);
    check("R10 no event after two edges", rd, 32'h0);
    step();
    bus_read(9'h014, rd);
    check("R10 event after three edges", rd, 32'h01);
    check("R9 irq via synchronized event", 32'(irq), 32'h1);

    // R10 input level readable on output-mode pins
    pin_in[23:16] = 8'h5A;
    repeat (3) step();
    bus_read(9'h064, rd);
    check("R10 level in output mode", rd, 32'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule